// File: doc/BRIEF.md
# Integer Multiply/Divide Unit with HI/LO Result Registers

This block performs 32-bit integer multiplication and division for a simple load/store processor core. The results go into two architectural result registers, HI and LO. A command strobe carries an opcode and two operands. The opcode selects one of the following operations:

- signed multiply
- unsigned multiply
- signed divide
- unsigned divide
- a direct write of HI
- a direct write of LO

A multiply finishes after a short fixed latency. A divide runs a restoring shift-subtract loop that retires one quotient bit per cycle. While an operation is in flight, the `busy` flag is high. HI and LO keep their previous contents until the operation completes.

Reads of HI and LO use a valid/ready handshake, and the unit is the only source of back-pressure. `rd_ready` is low for as long as `busy` is high. A requester may hold `rd_valid` high across the stall. The read completes in the first cycle in which both `rd_valid` and `rd_ready` are high. In that cycle `rd_hi` and `rd_lo` carry the register contents. In every other cycle both outputs read zero.

Commands are never back-pressured. A recognised command always takes effect, even while the unit is busy. Any work still in progress is discarded, and the new command alone determines what HI and LO end up holding.

Top module: `muldiv_hilo`

## Requirements
- R1: After reset, HI and LO are zero, `busy` is low and `rd_ready` is high.
- R2: Opcode 0 (signed multiply) writes the upper 32 bits of the 64-bit two's-complement product to HI and the lower 32 bits to LO.
- R3: Opcode 1 (unsigned multiply) writes the 64-bit unsigned product, upper half to HI and lower half to LO.
- R4: Opcode 2 (signed divide) with a nonzero divisor places the quotient, truncated toward zero, in LO. It places the remainder, which carries the dividend's sign, in HI. The case 0x80000000 divided by 0xFFFFFFFF gives LO = 0x80000000 and HI = 0.
- R5: Opcode 3 (unsigned divide) with a nonzero divisor places the unsigned quotient in LO and the remainder in HI.
- R6: For a divisor of zero, HI receives the dividend.
  - For signed divide, LO receives 1 when the dividend is negative and 0xFFFFFFFF otherwise.
  - For unsigned divide, LO receives 0xFFFFFFFF.
- R7: `busy` rises in the cycle after a command is taken. It stays high for exactly MUL_CYCLES cycles (default 2) for a multiply and WIDTH+1 cycles (default 33) for a divide. HI and LO do not change before the cycle in which `busy` falls.
- R8: Opcode 4 writes `cmd_a` into HI and opcode 5 writes `cmd_a` into LO. The write is visible on the next cycle and leaves the other register untouched. `busy` is not raised.
- R9: `rd_ready` is low while `busy` is high. `rd_hi` and `rd_lo` are zero unless `rd_valid` and `rd_ready` are both high.
- R10: A recognised command taken while busy aborts the operation in flight, including one in its completion cycle. The aborted result is never written.
- R11: Opcodes 6 and 7 have no effect. They change neither register and do not disturb an operation in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 3 | Operation code (0..5 defined) |
| cmd_a | input | WIDTH | First operand: multiplicand, dividend or value for a direct write |
| cmd_b | input | WIDTH | Second operand: multiplier or divisor |
| busy | output | 1 | An operation is in flight |
| rd_valid | input | 1 | Read request for HI and LO |
| rd_ready | output | 1 | Read can complete this cycle |
| rd_hi | output | WIDTH | HI contents during a completed read, else zero |
| rd_lo | output | WIDTH | LO contents during a completed read, else zero |

## Verification
The hardest situation to reach is a new command landing in the exact cycle in which a multiply is about to commit. Only the abort rule decides whether the old product or the new write survives. The bench counts cycles from the multiply's issue and drives a direct write of LO into the completion cycle. It then expects HI to keep its value from before the multiply.

Divides are also cut short part-way, either by a new multiply or by an undefined opcode. The bench confirms that the first is discarded and that the second leaves the divide untouched. Random commands with a fixed seed mix zero divisors, the most negative dividend and back-to-back direct writes around the directed cases.

// File: rtl/mdh_pkg.sv
package mdh_pkg;

  typedef enum logic [2:0] {
    OP_MUL_S  = 3'd0,
    OP_MUL_U  = 3'd1,
    OP_DIV_S  = 3'd2,
    OP_DIV_U  = 3'd3,
    OP_SET_HI = 3'd4,
    OP_SET_LO = 3'd5
  } mdh_op_e;

  typedef enum logic [1:0] {
    DV_IDLE = 2'd0,
    DV_PREP = 2'd1,
    DV_STEP = 2'd2
  } mdh_div_state_e;

  function automatic logic op_known(input logic [2:0] op);
    return op <= 3'd5;
  endfunction

endpackage

// File: rtl/mdh_mult.sv
module mdh_mult
  import mdh_pkg::*;
#(
  parameter int W   = 32,
  parameter int LAT = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         abort,
  input  logic         is_signed,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         active,
  output logic         done,
  output logic [W-1:0] prod_hi,
  output logic [W-1:0] prod_lo
);

  localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;
  localparam logic [CW-1:0] CNT_LOAD = CW'(LAT - 1);

  logic [W-1:0]   a_q, b_q;
  logic           sgn_q;
  logic [CW-1:0]  cnt_q;
  logic [2*W-1:0] ext_a, ext_b, prod;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q    <= '0;
      b_q    <= '0;
      sgn_q  <= 1'b0;
      cnt_q  <= '0;
      active <= 1'b0;
    end else if (start) begin
      a_q    <= a;
      b_q    <= b;
      sgn_q  <= is_signed;
      cnt_q  <= CNT_LOAD;
      active <= 1'b1;
    end else if (abort) begin
      active <= 1'b0;
    end else if (active) begin
      if (cnt_q == '0) active <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign ext_a   = {{W{sgn_q & a_q[W-1]}}, a_q};
  assign ext_b   = {{W{sgn_q & b_q[W-1]}}, b_q};
  assign prod    = ext_a * ext_b;
  assign prod_hi = prod[2*W-1:W];
  assign prod_lo = prod[W-1:0];
  assign done    = active && (cnt_q == '0);

  AST_MUL_ARMS_FULL_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (active && cnt_q == CNT_LOAD)); // R7

endmodule

// File: rtl/mdh_div.sv
module mdh_div
  import mdh_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         abort,
  input  logic         is_signed,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         active,
  output logic         done,
  output logic [W-1:0] res_hi,
  output logic [W-1:0] res_lo
);

  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  mdh_div_state_e st_q;
  logic [W-1:0]   a_q, b_q, rem_q, quo_q, dsr_q;
  logic           sgn_q, neg_q_q, neg_r_q, zero_q;
  logic [CW-1:0]  cnt_q;

  logic [W:0]     shifted, trial;
  logic           fit;
  logic [W-1:0]   rem_n, quo_n, q_fix, r_fix;

  // one restoring step: shift in the next dividend bit, try the subtraction
  assign shifted = {rem_q, quo_q[W-1]};
  assign trial   = shifted - {1'b0, dsr_q};
  assign fit     = ~trial[W];
  assign rem_n   = fit ? trial[W-1:0] : shifted[W-1:0];
  assign quo_n   = {quo_q[W-2:0], fit};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= DV_IDLE;
      a_q     <= '0;
      b_q     <= '0;
      sgn_q   <= 1'b0;
      rem_q   <= '0;
      quo_q   <= '0;
      dsr_q   <= '0;
      neg_q_q <= 1'b0;
      neg_r_q <= 1'b0;
      zero_q  <= 1'b0;
      cnt_q   <= '0;
    end else if (start) begin
      st_q  <= DV_PREP;
      a_q   <= a;
      b_q   <= b;
      sgn_q <= is_signed;
    end else if (abort) begin
      st_q <= DV_IDLE;
    end else begin
      case (st_q)
        DV_PREP: begin
          quo_q   <= (sgn_q && a_q[W-1]) ? (~a_q + 1'b1) : a_q;
          dsr_q   <= (sgn_q && b_q[W-1]) ? (~b_q + 1'b1) : b_q;
          rem_q   <= '0;
          neg_q_q <= sgn_q && (a_q[W-1] ^ b_q[W-1]);
          neg_r_q <= sgn_q && a_q[W-1];
          zero_q  <= (b_q == '0);
          cnt_q   <= '0;
          st_q    <= DV_STEP;
        end
        DV_STEP: begin
          rem_q <= rem_n;
          quo_q <= quo_n;
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) st_q <= DV_IDLE;
        end
        default: st_q <= DV_IDLE;
      endcase
    end
  end

  assign active = (st_q != DV_IDLE);
  assign done   = (st_q == DV_STEP) && (cnt_q == LAST);
  assign q_fix  = neg_q_q ? (~quo_n + 1'b1) : quo_n;
  assign r_fix  = neg_r_q ? (~rem_n + 1'b1) : rem_n;

  always_comb begin
    if (zero_q) begin
      res_hi = a_q;
      res_lo = neg_r_q ? W'(1) : '1;
    end else begin
      res_hi = r_fix;
      res_lo = q_fix;
    end
  end

  AST_DIV_ENTERS_PREP: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (st_q == DV_PREP)); // R7

  AST_DIV_PARTIAL_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == DV_STEP && !zero_q) |-> (rem_q < dsr_q)); // R4

endmodule

// File: rtl/mdh_regs.sv
module mdh_regs #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_hi,
  input  logic         wr_lo,
  input  logic [W-1:0] hi_d,
  input  logic [W-1:0] lo_d,
  input  logic         busy,
  input  logic         rd_valid,
  output logic         rd_ready,
  output logic [W-1:0] hi_q,
  output logic [W-1:0] lo_q,
  output logic [W-1:0] rd_hi,
  output logic [W-1:0] rd_lo
);

  logic xfer;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      if (wr_hi) hi_q <= hi_d;
      if (wr_lo) lo_q <= lo_d;
    end
  end

  assign rd_ready = ~busy;
  assign xfer     = rd_valid & rd_ready;
  assign rd_hi    = xfer ? hi_q : '0;
  assign rd_lo    = xfer ? lo_q : '0;

endmodule

// File: rtl/muldiv_hilo.sv
module muldiv_hilo
  import mdh_pkg::*;
#(
  parameter int WIDTH      = 32,
  parameter int MUL_CYCLES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic [WIDTH-1:0] cmd_a,
  input  logic [WIDTH-1:0] cmd_b,
  output logic             busy,
  input  logic             rd_valid,
  output logic             rd_ready,
  output logic [WIDTH-1:0] rd_hi,
  output logic [WIDTH-1:0] rd_lo
);

  logic cmd_take, mul_start, div_start, set_hi, set_lo;
  logic mul_active, mul_done, div_active, div_done;
  logic mul_commit, div_commit, wr_hi, wr_lo;
  logic [WIDTH-1:0] mul_hi, mul_lo, div_hi, div_lo, hi_d, lo_d, hi_q, lo_q;

  assign cmd_take  = cmd_valid && op_known(cmd_op);
  assign mul_start = cmd_valid && (cmd_op == OP_MUL_S || cmd_op == OP_MUL_U);
  assign div_start = cmd_valid && (cmd_op == OP_DIV_S || cmd_op == OP_DIV_U);
  assign set_hi    = cmd_valid && (cmd_op == OP_SET_HI);
  assign set_lo    = cmd_valid && (cmd_op == OP_SET_LO);

  mdh_mult #(.W(WIDTH), .LAT(MUL_CYCLES)) u_mult (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (mul_start),
    .abort     (cmd_take),
    .is_signed (cmd_op == OP_MUL_S),
    .a         (cmd_a),
    .b         (cmd_b),
    .active    (mul_active),
    .done      (mul_done),
    .prod_hi   (mul_hi),
    .prod_lo   (mul_lo)
  );

  mdh_div #(.W(WIDTH)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (div_start),
    .abort     (cmd_take),
    .is_signed (cmd_op == OP_DIV_S),
    .a         (cmd_a),
    .b         (cmd_b),
    .active    (div_active),
    .done      (div_done),
    .res_hi    (div_hi),
    .res_lo    (div_lo)
  );

  // a command in the completion cycle discards the finishing result
  assign mul_commit = mul_done & ~cmd_take;
  assign div_commit = div_done & ~cmd_take;
  assign wr_hi      = mul_commit | div_commit | set_hi;
  assign wr_lo      = mul_commit | div_commit | set_lo;
  assign hi_d       = mul_commit ? mul_hi : (div_commit ? div_hi : cmd_a);
  assign lo_d       = mul_commit ? mul_lo : (div_commit ? div_lo : cmd_a);
  assign busy       = mul_active | div_active;

  mdh_regs #(.W(WIDTH)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_hi    (wr_hi),
    .wr_lo    (wr_lo),
    .hi_d     (hi_d),
    .lo_d     (lo_d),
    .busy     (busy),
    .rd_valid (rd_valid),
    .rd_ready (rd_ready),
    .hi_q     (hi_q),
    .lo_q     (lo_q),
    .rd_hi    (rd_hi),
    .rd_lo    (rd_lo)
  );

  AST_SET_HI_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_SET_HI) |=> (hi_q == $past(cmd_a) && !busy)); // R8

  AST_SET_LO_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_SET_LO) |=> (lo_q == $past(cmd_a) && !busy)); // R8

  AST_IDLE_UNKNOWN_OP_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !op_known(cmd_op) && !busy) |=> ($stable(hi_q) && $stable(lo_q) && !busy)); // R11

  AST_NO_EARLY_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cmd_valid && !mul_done && !div_done) |=> ($stable(hi_q) && $stable(lo_q) && busy)); // R7

  AST_ABORT_CLEARS_DIV: assert property (@(posedge clk) disable iff (!rst_n)
    (div_active && mul_start) |=> !div_active); // R10

endmodule

// File: tb/muldiv_hilo_tb.sv
`timescale 1ns/1ps
module muldiv_hilo_tb;
  localparam int W       = 32;
  localparam int MUL_CYC = 2;
  localparam int DIV_CYC = W + 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0;
  logic [2:0]   cmd_op = 3'd0;
  logic [W-1:0] cmd_a = '0, cmd_b = '0;
  logic         rd_valid = 1'b0;
  logic         busy, rd_ready;
  logic [W-1:0] rd_hi, rd_lo;

  int checks = 0, errors = 0;
  logic [W-1:0] exp_hi = '0, exp_lo = '0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  muldiv_hilo #(.WIDTH(W), .MUL_CYCLES(MUL_CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_a(cmd_a), .cmd_b(cmd_b), .busy(busy), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_hi(rd_hi), .rd_lo(rd_lo)
  );

  function automatic logic [63:0] model(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
    logic [63:0] ea, eb;
    logic [31:0] q, r;
    case (op)
      3'd0: begin ea = {{32{a[31]}}, a}; eb = {{32{b[31]}}, b}; return ea * eb; end
      3'd1: begin ea = {32'd0, a}; eb = {32'd0, b}; return ea * eb; end
      3'd2: begin
        if (b == 32'd0) return {a, (a[31] ? 32'd1 : 32'hFFFF_FFFF)};
        if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return {32'd0, 32'h8000_0000};
        q = $signed(a) / $signed(b);
        r = $signed(a) % $signed(b);
        return {r, q};
      end
      3'd3: begin
        if (b == 32'd0) return {a, 32'hFFFF_FFFF};
        return {a % b, a / b};
      end
      default: return 64'd0;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_a = a; cmd_b = b;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy === 1'b1 && n < 200) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic read_chk(input string req);
    @(negedge clk);
    rd_valid = 1'b1;
    #1;
    chk(req, "rd_ready", 64'(rd_ready), 64'd1);
    chk(req, "HI", 64'(rd_hi), 64'(exp_hi));
    chk(req, "LO", 64'(rd_lo), 64'(exp_lo));
    rd_valid = 1'b0;
  endtask

  task automatic run_op(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b, input string req);
    int n;
    issue(op, a, b);
    if (op <= 3'd3) begin
      count_busy(n);
      chk(req, "busy cycles", 64'(n), (op <= 3'd1) ? 64'(MUL_CYC) : 64'(DIV_CYC));
      {exp_hi, exp_lo} = model(op, a, b);
    end else if (op == 3'd4) begin
      chk(req, "busy after direct write", 64'(busy), 64'd0);
      exp_hi = a;
    end else if (op == 3'd5) begin
      chk(req, "busy after direct write", 64'(busy), 64'd0);
      exp_lo = a;
    end
    read_chk(req);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n;
    logic [2:0] rop;
    logic [31:0] ra, rb;
    void'($urandom(32'h5EED_0042));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1", "busy", 64'(busy), 64'd0);
    chk("R1", "rd_ready", 64'(rd_ready), 64'd1);
    read_chk("R1");

    // R2 / R3 multiplies
    run_op(3'd0, 32'hFFFF_FFFD, 32'd5, "R2");
    run_op(3'd0, 32'h8000_0000, 32'h8000_0000, "R2");
    run_op(3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3");
    run_op(3'd1, 32'h8000_0000, 32'd2, "R3");

    // R4 signed divide including the overflow case
    run_op(3'd2, 32'hFFFF_FFF9, 32'd2, "R4");
    run_op(3'd2, 32'd7, 32'hFFFF_FFFE, "R4");
    run_op(3'd2, 32'h8000_0000, 32'hFFFF_FFFF, "R4");
    run_op(3'd2, 32'h8000_0000, 32'd1, "R4");

    // R5 unsigned divide
    run_op(3'd3, 32'hFFFF_FFFF, 32'd10, "R5");
    run_op(3'd3, 32'd5, 32'd9, "R5");

    // R6 divide by zero
    run_op(3'd2, 32'hFFFF_FFFB, 32'd0, "R6");
    run_op(3'd2, 32'd9, 32'd0, "R6");
    run_op(3'd3, 32'h8000_0000, 32'd0, "R6");

    // R8 direct writes
    run_op(3'd4, 32'h1234_5678, 32'd0, "R8");
    run_op(3'd5, 32'h9ABC_DEF0, 32'd0, "R8");

    // R9 read stalled while busy
    issue(3'd3, 32'd1000, 32'd7);
    rd_valid = 1'b1;
    #1;
    chk("R9", "rd_ready while busy", 64'(rd_ready), 64'd0);
    chk("R9", "rd_hi gated", 64'(rd_hi), 64'd0);
    chk("R9", "rd_lo gated", 64'(rd_lo), 64'd0);
    rd_valid = 1'b0;
    count_busy(n);
    {exp_hi, exp_lo} = model(3'd3, 32'd1000, 32'd7);
    read_chk("R9");

    // R10 divide aborted by a multiply mid-way
    issue(3'd2, 32'd100, 32'd7);
    repeat (10) @(negedge clk);
    run_op(3'd0, 32'd11, 32'hFFFF_FFFF, "R10");

    // R10 command in the multiply's completion cycle
    run_op(3'd4, 32'hCAFE_0001, 32'd0, "R10");
    issue(3'd1, 32'd3, 32'd4);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd5; cmd_a = 32'h0000_ABCD; cmd_b = 32'd0;
    @(negedge clk);
    cmd_valid = 1'b0;
    exp_lo = 32'h0000_ABCD;
    chk("R10", "busy after completion-cycle abort", 64'(busy), 64'd0);
    read_chk("R10");

    // R11 unknown opcode while idle and during a divide
    issue(3'd7, 32'hDEAD_BEEF, 32'h1);
    chk("R11", "busy after opcode 7", 64'(busy), 64'd0);
    read_chk("R11");
    issue(3'd2, 32'hFFFF_FF00, 32'd3);
    repeat (5) @(negedge clk);
    issue(3'd6, 32'h1, 32'h2);
    count_busy(n);
    {exp_hi, exp_lo} = model(3'd2, 32'hFFFF_FF00, 32'd3);
    read_chk("R11");

    // R7 and R2-R6, R8 under random traffic
    for (int i = 0; i < 150; i++) begin
      rop = 3'($urandom % 6);
      ra  = $urandom;
      rb  = (($urandom % 8) == 0) ? 32'd0 : $urandom;
      if (($urandom % 10) == 0) ra = 32'h8000_0000;
      if (($urandom % 10) == 0) rb = 32'hFFFF_FFFF;
      case (rop)
        3'd0: run_op(rop, ra, rb, "R2");
        3'd1: run_op(rop, ra, rb, "R3");
        3'd2: run_op(rop, ra, rb, (rb == 0) ? "R6" : "R4");
        3'd3: run_op(rop, ra, rb, (rb == 0) ? "R6" : "R5");
        default: run_op(rop, ra, rb, "R8");
      endcase
    end

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule